// File: doc/BRIEF.md
# Protection Register Program Command Handler

This block is the serial-slave front end of a NOR memory. Its only job is to program a 16-bit protection register through a three-byte command frame. Every serial input is sampled with the system clock. A host uses the block in three steps. It first sends a write-enable frame to arm the block. It then sends the program instruction followed by two data bytes. Finally it polls a status byte until the busy flag drops.

A program frame is accepted only when chip select rises directly after the last of the sixteen data bits. The write-enable latch must be set at that moment, and no operation may already be running. An accepted frame starts a self-timed operation that lasts a parameterised number of clock cycles. While it runs, the busy flag reads 1. When it ends, the block commits the new value and clears the write-enable latch. If the lock input holds the register, the block sets the error flag instead and leaves the value unchanged.

Top module: `flash_prot_prog`

## Requirements
- R1: After reset the status byte reads 00h, `prot_q` equals `RESET_VAL` and `spi_miso` is 0 while chip select is high.
- R2: A frame holding instruction 06h and exactly 8 clocked bits sets the write-enable flag, which is status bit 1.
- R3: Instruction 2Fh followed by 16 data bits writes the register when the operation ends. The first data byte becomes bits 7:0 and the second becomes bits 15:8, each byte sent MSB first.
- R4: A program frame that ends with any bit count other than 24 is discarded. No operation starts, the register keeps its value and the write-enable flag stays set.
- R5: A program frame that ends while the write-enable flag is 0 is discarded.
- R6: The busy flag, status bit 0, rises only after the chip-select rise that ends an accepted frame. It stays 1 for `PROG_CYCLES` clocks and then reads 0.
- R7: The write-enable flag is 0 once the operation completes.
- R8: If `prot_lock` is 1 when a frame is accepted, the busy flag still pulses and clears. The error flag, status bit 6, reads 1, and the register keeps its value.
- R9: Instruction 05h returns the status byte MSB first on `spi_miso` and repeats it for as long as chip select stays low.
- R10: While the busy flag is 1, program and write-enable frames are ignored, but status reads are still served.
- R11: An accepted program on an unlocked register clears a previously set error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| prot_lock | input | 1 | When 1, programming the register fails |
| spi_miso | output | 1 | Serial data out, 0 when idle |
| prot_q | output | 16 | Current protection register value |

## Verification
The hardest state to reach is the busy window while a second frame arrives, because a complete program frame takes longer than a short operation. The bench therefore raises `PROG_CYCLES` so that a status read, a write-enable frame and a full program frame all fit inside one operation. After completion it confirms that neither late frame had an effect. The frames with the wrong length stop chip select one bit early and one bit late, which exercises both sides of the exact-count rule.

// File: rtl/flash_prot_prog.sv
module flash_prot_prog #(
  parameter int          PROG_CYCLES = 200,
  parameter logic [15:0] RESET_VAL   = 16'h0000,
  parameter logic [7:0]  OP_PROG     = 8'h2F,
  parameter logic [7:0]  OP_WREN     = 8'h06,
  parameter logic [7:0]  OP_RDSR     = 8'h05
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        spi_sck,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  input  logic        prot_lock,
  output logic        spi_miso,
  output logic [15:0] prot_q
);
  localparam int          TW       = $clog2(PROG_CYCLES + 1);
  localparam logic [4:0]  CMD_LEN  = 5'd8;
  localparam logic [4:0]  PROG_LEN = 5'd24;
  localparam logic [4:0]  CNT_MAX  = 5'd31;

  logic [1:0]    sck_m, cs_m, si_m;
  logic          sck_d, cs_d;
  logic [4:0]    bit_cnt;
  logic [15:0]   sh;
  logic [7:0]    cmd_q;
  logic          rd_act;
  logic [7:0]    out_sr;
  logic [2:0]    out_idx;
  logic          wip, wel, perr;
  logic [TW-1:0] tmr;
  logic [15:0]   pend;

  wire sck_s = sck_m[1];
  wire cs_s  = cs_m[1];
  wire si_s  = si_m[1];

  wire sck_rise = !cs_s && sck_s && !sck_d;
  wire sck_fall = !cs_s && !sck_s && sck_d;
  wire cs_rise  = cs_s && !cs_d;

  wire [7:0] status  = {1'b0, perr, 4'b0000, wel, wip};
  wire       go_prog = cs_rise && cmd_q == OP_PROG && bit_cnt == PROG_LEN && wel && !wip;
  wire       go_wren = cs_rise && cmd_q == OP_WREN && bit_cnt == CMD_LEN && !wip;
  wire       done    = wip && tmr == '0;

  assign spi_miso = rd_act & out_sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m <= '0;
      cs_m  <= 2'b11;
      si_m  <= '0;
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_m <= {sck_m[0], spi_sck};
      cs_m  <= {cs_m[0], spi_cs_n};
      si_m  <= {si_m[0], spi_mosi};
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      sh      <= '0;
      cmd_q   <= '0;
    end else if (cs_s) begin
      bit_cnt <= '0;
    end else if (sck_rise) begin
      sh <= {sh[14:0], si_s};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 5'd1;
      if (bit_cnt == CMD_LEN - 5'd1) cmd_q <= {sh[6:0], si_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act  <= 1'b0;
      out_sr  <= '0;
      out_idx <= '0;
    end else if (cs_s) begin
      rd_act <= 1'b0;
    end else if (sck_fall) begin
      if (!rd_act) begin
        if (bit_cnt == CMD_LEN && cmd_q == OP_RDSR) begin
          rd_act  <= 1'b1;
          out_sr  <= status;
          out_idx <= '0;
        end
      end else if (out_idx == 3'd7) begin
        out_sr  <= status;
        out_idx <= '0;
      end else begin
        out_sr  <= {out_sr[6:0], 1'b0};
        out_idx <= out_idx + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip    <= 1'b0;
      wel    <= 1'b0;
      perr   <= 1'b0;
      tmr    <= '0;
      pend   <= '0;
      prot_q <= RESET_VAL;
    end else if (go_prog) begin
      wip  <= 1'b1;
      tmr  <= TW'(PROG_CYCLES - 1);
      perr <= prot_lock;
      pend <= {sh[7:0], sh[15:8]};
    end else if (go_wren) begin
      wel <= 1'b1;
    end else if (done) begin
      wip <= 1'b0;
      wel <= 1'b0;
      if (!perr) prot_q <= pend;
    end else if (wip) begin
      tmr <= tmr - TW'(1);
    end
  end
endmodule

module flash_prot_prog_chk #(
  parameter int PROG_CYCLES = 200,
  parameter int TW          = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_s,
  input logic          cs_rise,
  input logic          wip,
  input logic          wel,
  input logic          perr,
  input logic [TW-1:0] tmr,
  input logic [15:0]   prot_q,
  input logic          spi_miso
);
  assert_idle_miso_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |-> !spi_miso);
  assert_update_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_q) |-> $fell(wip));
  assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cs_rise));
  assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> (int'(tmr) < PROG_CYCLES));
  assert_wel_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);
  assert_lock_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(wip) && perr) |-> $stable(prot_q));
endmodule

bind flash_prot_prog flash_prot_prog_chk #(.PROG_CYCLES(PROG_CYCLES), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_rise(cs_rise), .wip(wip), .wel(wel),
  .perr(perr), .tmr(tmr), .prot_q(prot_q), .spi_miso(spi_miso)
);

// File: tb/sim_flash_prot_prog.sv
`timescale 1ns/1ps
module sim_flash_prot_prog;
  localparam int          PC    = 1000;
  localparam logic [15:0] RVAL  = 16'hC3C3;
  localparam int          HP    = 50;

  logic clk = 0, rst_n = 0;
  logic sck = 0, cs_n = 1, mosi = 0, lock = 0;
  logic miso;
  logic [15:0] prot_q;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_prot_prog #(.PROG_CYCLES(PC), .RESET_VAL(RVAL)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .prot_lock(lock), .spi_miso(miso), .prot_q(prot_q));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic r);
    mosi = b;
    #HP;
    r = miso;
    sck = 1;
    #HP;
    sck = 0;
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) bit_x(tx[i], rx[i]);
  endtask

  task automatic cs_on();
    cs_n = 0;
    #HP;
  endtask

  task automatic cs_off();
    #HP;
    cs_n = 1;
    #(4 * HP);
  endtask

  task automatic read_status(output logic [7:0] s);
    logic [7:0] d;
    cs_on();
    byte_x(8'h05, d);
    byte_x(8'h00, s);
    cs_off();
  endtask

  task automatic wren();
    logic [7:0] d;
    cs_on();
    byte_x(8'h06, d);
    cs_off();
  endtask

  task automatic prog_frame(input logic [15:0] v, input int nbits);
    logic [7:0] d;
    logic [16:0] bits;
    logic r;
    bits = {v[7:0], v[15:8], 1'b0};
    cs_on();
    byte_x(8'h2F, d);
    for (int i = 0; i < nbits; i++) bit_x(bits[16 - i], r);
    cs_off();
  endtask

  task automatic wait_op();
    repeat (PC + 200) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    check("R1 miso idle", {15'd0, miso}, 16'h0000);
    check("R1 prot_q reset", prot_q, RVAL);
    read_status(s);
    check("R1 status reset", {8'h00, s}, 16'h0000);
  endtask

  task automatic t_wren();
    logic [7:0] s;
    wren();
    read_status(s);
    check("R2 wel set", {8'h00, s}, 16'h0002);
  endtask

  task automatic t_prog();
    logic [7:0] s;
    prog_frame(16'h1234, 16);
    read_status(s);
    check("R6 wip during op", {8'h00, s}, 16'h0003);
    check("R3 value held during op", prot_q, RVAL);
    wait_op();
    read_status(s);
    check("R6 R7 status after op", {8'h00, s}, 16'h0000);
    check("R3 byte order", prot_q, 16'h1234);
  endtask

  task automatic t_nowel();
    logic [7:0] s;
    prog_frame(16'hBEEF, 16);
    read_status(s);
    check("R5 no op without wel", {8'h00, s}, 16'h0000);
    wait_op();
    check("R5 value kept", prot_q, 16'h1234);
  endtask

  task automatic t_bad_len();
    logic [7:0] s;
    wren();
    prog_frame(16'h7777, 15);
    read_status(s);
    check("R4 short frame status", {8'h00, s}, 16'h0002);
    prog_frame(16'h7777, 17);
    read_status(s);
    check("R4 long frame status", {8'h00, s}, 16'h0002);
    wait_op();
    check("R4 value kept", prot_q, 16'h1234);
  endtask

  task automatic t_repeat();
    logic [7:0] s, d;
    cs_on();
    byte_x(8'h05, d);
    for (int k = 0; k < 3; k++) begin
      byte_x(8'h00, s);
      check("R9 repeated status byte", {8'h00, s}, 16'h0002);
    end
    cs_off();
  endtask

  task automatic t_busy();
    logic [7:0] s;
    prog_frame(16'h5678, 16);
    read_status(s);
    check("R10 status served while busy", {8'h00, s}, 16'h0003);
    wren();
    prog_frame(16'h9999, 16);
    wait_op();
    read_status(s);
    check("R10 wren ignored while busy", {8'h00, s}, 16'h0000);
    check("R10 program ignored while busy", prot_q, 16'h5678);
  endtask

  task automatic t_lock();
    logic [7:0] s;
    lock = 1;
    wren();
    prog_frame(16'hAAAA, 16);
    read_status(s);
    check("R8 wip pulses when locked", {8'h00, s}, 16'h0043);
    wait_op();
    read_status(s);
    check("R8 perr set after locked op", {8'h00, s}, 16'h0040);
    check("R8 value kept when locked", prot_q, 16'h5678);
    lock = 0;
  endtask

  task automatic t_perr_clear();
    logic [7:0] s;
    wren();
    prog_frame(16'h0F0F, 16);
    wait_op();
    read_status(s);
    check("R11 perr cleared", {8'h00, s}, 16'h0000);
    check("R11 value written", prot_q, 16'h0F0F);
  endtask

  initial begin
    #(2_000_000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_wren();
    t_prog();
    t_nowel();
    t_bad_len();
    t_repeat();
    t_busy();
    t_lock();
    t_perr_clear();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule